// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block gates a group of clock outputs on and off under a stop request that is active low and asynchronous to every clock. The request passes through a synchronizer in the domain of the gated group. Every output's enable register updates only on the falling edge of the source clock. As a result, an output can only stop or restart while the source clock is low, and every high pulse it drives has full width.

Each output has a free-running mask bit that exempts it from the stop request. An early or always-on member of the group is wired through such a bit. A parameter selects one of two latency profiles. The processor-bus profile synchronizes on two falling edges and then loads the enable. The peripheral-bus profile captures the request on a rising edge and loads the enable on the falling edge that follows. Clocks are modelled as ordinary digital signals.

Top module: `clk_stop_ctrl`

## Requirements
- R1: The stop input is sampled only by edges of `clk_i`. The processor profile samples it through two falling-edge stages. The peripheral profile samples it through one rising-edge stage. In both profiles a per-output falling-edge enable stage follows.
- R2: A gated output that is stopped stays at 0. No output is ever high while `clk_i` is low.
- R3: Every high pulse on any output lasts exactly one half period of `clk_i`, including pulses next to a stop, a restart or a mask change.
- R4: Processor profile (`PROFILE` = 0): let `stop_ni` change during the high phase that follows rising edge E0. Pulses on E1 and E2 keep the old state. The new state applies from E3. This holds for both stopping (1 to 0) and restarting (0 to 1).
- R5: Peripheral profile (`PROFILE` = 1): under the same stimulus, the pulse on E1 keeps the old state and the new state applies from E2. This holds for both stopping and restarting.
- R6: An output whose bit in `free_run_i` is 1 follows `clk_i` regardless of `stop_ni`.
- R7: A change of `free_run_i` during the high phase after E0 takes effect from the pulse on E1.
- R8: While `rst_ni` is low, every output follows `clk_i`, and the synchronizer is preset to the not-stopped state.
- R9: A low request on `stop_ni` that lasts exactly one period suppresses exactly one pulse: E3 in the processor profile, E2 in the peripheral profile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock of the gated group |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stop_ni | input | 1 | Asynchronous stop request, active low |
| free_run_i | input | N_OUT | Per-output exemption from the stop request (1 = always running) |
| clk_o | output | N_OUT | Gated clock outputs |

## Verification
Every stimulus is applied 5 ns into a high phase of the 50 MHz clock. The bench's reference model records the inputs at each rising edge. It predicts the level of each output in that edge's high phase from the request seen two edges earlier (processor profile) or one edge earlier (peripheral profile), and from the mask seen at the same edge. Outputs are compared 2 ns after each rising edge and again in the low phase. Explicit pulse counts confirm the edge on which each stop and each restart first takes effect. Every high pulse on every output is timed against the half period.

// File: rtl/clk_stop_pkg.sv
`timescale 1ns/1ps
package clk_stop_pkg;
  typedef enum logic {
    PROF_CPU = 1'b0,
    PROF_PCI = 1'b1
  } stop_prof_e;
endpackage

// File: rtl/stop_sync.sv
`timescale 1ns/1ps
module stop_sync import clk_stop_pkg::*; #(
  parameter stop_prof_e PROFILE = PROF_CPU
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_ni,
  output logic run_o
);

  generate
    if (PROFILE == PROF_CPU) begin : g_cpu
      logic [1:0] sync_q;
      logic [1:0] warm_q;

      // two falling-edge stages; preset to "running"
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= 2'b11;
        else         sync_q <= {sync_q[0], stop_ni};
      end

      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              warm_q <= 2'd0;
        else if (warm_q != 2'd3)  warm_q <= warm_q + 2'd1;
      end

      assign run_o = sync_q[1];

      // R1: output mirrors the input seen two falling edges earlier
      a_r1_cpu_sync_depth: assert property (@(negedge clk_i) disable iff (!rst_ni)
        (warm_q >= 2'd2) |-> (run_o == $past(stop_ni, 2)));
    end else begin : g_pci
      logic capt_q;
      logic warm_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) capt_q <= 1'b1;
        else         capt_q <= stop_ni;
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) warm_q <= 1'b0;
        else         warm_q <= 1'b1;
      end

      assign run_o = capt_q;

      // R1: one rising-edge capture stage
      a_r1_pci_sync_depth: assert property (@(posedge clk_i) disable iff (!rst_ni)
        warm_q |-> (run_o == $past(stop_ni)));
    end
  endgenerate

endmodule

// File: rtl/clk_gate_cell.sv
`timescale 1ns/1ps
module clk_gate_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic free_run_i,
  output logic clk_o
);

  logic en_q;

  // enable moves only while clk_i is low: no runt or clipped high phase
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b1;
    else         en_q <= run_i | free_run_i;
  end

  assign clk_o = clk_i & en_q;

  // R6: exempt output keeps its enable
  a_r6_free_run_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_run_i && $past(free_run_i)) |-> en_q);

  // R2: stopped and not exempt -> enable held off
  a_r2_stop_holds_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !$past(run_i) && !free_run_i && !$past(free_run_i)) |-> !en_q);

  // R8: reset leaves the output enabled
  a_r8_reset_enabled: assert property (@(posedge clk_i)
    !rst_ni |-> en_q);

endmodule

// File: rtl/clk_stop_ctrl.sv
`timescale 1ns/1ps
module clk_stop_ctrl import clk_stop_pkg::*; #(
  parameter int unsigned N_OUT   = 4,
  parameter stop_prof_e  PROFILE = PROF_CPU
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_ni,
  input  logic [N_OUT-1:0] free_run_i,
  output logic [N_OUT-1:0] clk_o
);

  logic run_sync;

  stop_sync #(.PROFILE(PROFILE)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stop_ni (stop_ni),
    .run_o   (run_sync)
  );

  generate
    for (genvar i = 0; i < N_OUT; i++) begin : g_out
      clk_gate_cell u_cell (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .run_i      (run_sync),
        .free_run_i (free_run_i[i]),
        .clk_o      (clk_o[i])
      );
    end
  endgenerate

endmodule

// File: tb/clk_stop_ctrl_tb.sv
`timescale 1ns/1ps
module clk_stop_ctrl_tb;
  import clk_stop_pkg::*;

  localparam int N = 4;
  localparam int HIST = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic stop_n = 1'b1;
  logic [N-1:0] mask = '0;
  logic [N-1:0] clk_cpu, clk_pci;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  clk_stop_ctrl #(.N_OUT(N), .PROFILE(PROF_CPU)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .stop_ni(stop_n), .free_run_i(mask), .clk_o(clk_cpu));

  clk_stop_ctrl #(.N_OUT(N), .PROFILE(PROF_PCI)) u_dut_pci (
    .clk_i(clk), .rst_ni(rst_n), .stop_ni(stop_n), .free_run_i(mask), .clk_o(clk_pci));

  bit           req_hist [0:HIST-1];
  logic [N-1:0] mask_hist[0:HIST-1];
  bit           rst_hist [0:HIST-1];
  int cyc = 0;

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference: enable seen at edge k = reset ? 1 : mask(k) | request(k-d)
  function automatic logic [N-1:0] model(int k, int d);
    logic r;
    if (!rst_hist[k]) return '1;
    r = (k >= d) ? req_hist[k-d] : 1'b1;
    return mask_hist[k] | {N{r}};
  endfunction

  always @(posedge clk) begin : sampler
    int k;
    k = cyc;
    cyc++;
    #1;
    if (k < HIST) begin
      req_hist[k]  = stop_n;
      mask_hist[k] = mask;
      rst_hist[k]  = rst_n;
    end
    #1;
    if (k < HIST) begin
      chk("R4 R6 R7 R8 R9 cpu high phase", clk_cpu, model(k, 2));
      chk("R5 R6 R7 R8 R9 pci high phase", clk_pci, model(k, 1));
    end
    #10;
    chk("R2 cpu low phase", clk_cpu, '0);
    chk("R2 pci low phase", clk_pci, '0);
  end

  // R3: every high pulse is a full half period
  generate
    for (genvar i = 0; i < N; i++) begin : g_pw
      realtime tr_c = 0.0;
      realtime tr_p = 0.0;
      always @(posedge clk_cpu[i]) tr_c = $realtime;
      always @(posedge clk_pci[i]) tr_p = $realtime;
      always @(negedge clk_cpu[i]) if (tr_c > 0.0) chk_int("R3 cpu pulse width", int'($realtime - tr_c), 10);
      always @(negedge clk_pci[i]) if (tr_p > 0.0) chk_int("R3 pci pulse width", int'($realtime - tr_p), 10);
    end
  endgenerate

  int pc_cpu = 0;
  int pc_pci = 0;
  always @(posedge clk_cpu[0]) pc_cpu++;
  always @(posedge clk_pci[0]) pc_pci++;

  task automatic at_edge(int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  initial begin : main
    int p_c, p_p;
    mask = 4'b1000;
    #1 rst_n = 1'b0;
    at_edge(3);
    rst_n = 1'b1;
    at_edge(4);

    // stop: count pulses still passed on bit 0
    stop_n = 1'b0;
    p_c = pc_cpu; p_p = pc_pci;
    repeat (8) @(posedge clk);
    #3;
    chk_int("R4 cpu pulses after stop", pc_cpu - p_c, 2);
    chk_int("R5 pci pulses after stop", pc_pci - p_p, 1);

    // exempt a bit while stopped, then withdraw it
    at_edge(1);
    mask[1] = 1'b1;
    at_edge(4);
    mask[1] = 1'b0;
    at_edge(4);

    // restart: first pulse edge
    stop_n = 1'b1;
    p_c = pc_cpu; p_p = pc_pci;
    @(posedge clk); #3;
    chk_int("R4 cpu restart E1", pc_cpu - p_c, 0);
    chk_int("R5 pci restart E1", pc_pci - p_p, 0);
    @(posedge clk); #3;
    chk_int("R4 cpu restart E2", pc_cpu - p_c, 0);
    chk_int("R5 pci restart E2", pc_pci - p_p, 1);
    @(posedge clk); #3;
    chk_int("R4 cpu restart E3", pc_cpu - p_c, 1);
    chk_int("R5 pci restart E3", pc_pci - p_p, 2);

    // one-period request
    at_edge(3);
    stop_n = 1'b0;
    p_c = pc_cpu; p_p = pc_pci;
    at_edge(1);
    stop_n = 1'b1;
    repeat (6) @(posedge clk);
    #3;
    chk_int("R9 cpu short request", pc_cpu - p_c, 6);
    chk_int("R9 pci short request", pc_pci - p_p, 6);

    // alternating request and mask patterns
    for (int j = 0; j < 10; j++) begin
      at_edge(2);
      stop_n = ~stop_n;
      if (j % 3 == 0) mask[2] = ~mask[2];
    end
    at_edge(6);
    stop_n = 1'b1;
    at_edge(6);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule